// File: doc/BRIEF.md
# Triangle Spread-Spectrum Divide-Word Modulator

This block sits between the programmed feedback setting of a fractional-N synthesizer and the divider that uses it. It takes a base divide word, made of an integer part and an 18-bit fraction, and returns a word that moves in a triangle around that base. The effect is to smear the synthesized clock's energy over a band. The sweep is set by four register values: a step size in fraction LSBs, a half-period step count, an adjustment period that spaces the steps, and a two-bit spread control field. Working these values out from a modulation rate and a deviation target is done outside the block. A typical setting uses a modulation rate near 31.5 kHz, a deviation near 4800 ppm and an adjustment period of 2.

The block runs on the reference clock and gives one new word per reference cycle. A step is applied once every adj_per+1 enabled cycles. The sweep reverses after a full leg of half_per+1 steps. In down-spread mode the word only goes below the base. In center mode the first leg is half as long, so the triangle is centred on the base. When spread is off, the base word passes through unchanged.

Top module: `ssc_tri_mod`

## Requirements
- R1: While rst_n is low, the output word {div_int, div_frac} is zero.
- R2: With spread_ctrl bit 1 (enable) clear, the output in the next cycle equals the base word {base_int, base_frac} sampled in this cycle, whatever the value of spread_ctrl bit 0.
- R3: With enable set, a step is applied on every (adj_per+1)-th enabled cycle. The output at the n-th enabled cycle (n counted from 1) reflects floor((n-1)/(adj_per+1)) steps.
- R4: A step adds or subtracts step_size in units of the fraction LSB across the whole word, so carries and borrows pass into the integer part. The sum wraps modulo 2^(INT_W+FRAC_W).
- R5: In down-spread mode (spread_ctrl bit 0 clear), with L = half_per+1, the offset goes down by L steps, then up by L steps, and then repeats, so it stays between -L*step_size and 0.
- R6: In center mode (spread_ctrl bit 0 set), the first leg goes down by F = ceil(L/2) steps. After that, legs of L steps go up and down alternately, so for even L the offset spans from -L/2 to +L/2 steps.
- R7: Clearing enable zeroes the offset and resets the step spacing, the leg position and the direction. The next enable starts again from the base word with a first downward leg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_int | input | INT_W | Integer part of the programmed divide word |
| base_frac | input | FRAC_W | Fractional part of the programmed divide word |
| step_size | input | CNT_W | Step size in fraction LSBs |
| half_per | input | CNT_W | Leg length minus one, in steps |
| adj_per | input | CNT_W | Cycles between steps minus one |
| spread_ctrl | input | 2 | Bit 1 enables spread, bit 0 selects center mode |
| div_int | output | INT_W | Integer part of the effective divide word |
| div_frac | output | FRAC_W | Fractional part of the effective divide word |

## Verification
The bench sweeps every combination of adjustment periods 0 to 2, half-periods 0, 1, 2, 3 and 5, both spread modes, and a small and a full-scale step. It compares every output cycle against a closed-form triangle position. Half-period 0 and odd leg lengths show whether the first leg in center mode is rounded up. Adjustment periods above zero show whether steps are spaced correctly rather than applied every cycle. The base fraction is placed just below a carry, and a zero base is swept in down mode, so that carry into the integer part and wrap-around are told apart from truncation. Each run stops at an uneven point, so the following disable and restart shows whether all sweep state is cleared.

// File: rtl/ssc_tri_pkg.sv
package ssc_tri_pkg;

   // Bit positions inside the spread control field
   localparam int CTRL_EN_BIT  = 1;
   localparam int CTRL_CTR_BIT = 0;

   // Sweep direction
   typedef enum logic {
      DIR_UP = 1'b0,
      DIR_DN = 1'b1
   } ssc_dir_e;

endpackage

// File: rtl/ssc_tick_gen.sv
// Produces one step strobe every adj_per+1 enabled cycles.
module ssc_tick_gen #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [CNT_W-1:0] adj_per,
   output logic             tick
);

   logic [CNT_W-1:0] gap_cnt;

   assign tick = en && (gap_cnt == adj_per);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap_cnt <= '0;
      end else if (!en || tick) begin
         gap_cnt <= '0;
      end else begin
         gap_cnt <= gap_cnt + 1'b1;
      end
   end

endmodule

// File: rtl/ssc_leg_ctrl.sv
// Tracks position within the current leg and the sweep direction.
module ssc_leg_ctrl
   import ssc_tri_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter bit CENTER_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             center,
   input  logic             tick,
   input  logic [CNT_W-1:0] half_per,
   output ssc_dir_e         dir
);

   logic [CNT_W-1:0] leg_pos;
   logic [CNT_W-1:0] leg_last;
   logic             first_leg;
   logic             center_eff;
   logic             leg_end;
   ssc_dir_e         dir_q;

   generate
      if (CENTER_EN) begin : g_center
         assign center_eff = center;
      end else begin : g_down_only
         assign center_eff = 1'b0;
      end
   endgenerate

   // Center mode: first leg is ceil((half_per+1)/2) steps, i.e. last index half_per>>1
   assign leg_last = (center_eff && first_leg) ? (half_per >> 1) : half_per;
   assign leg_end  = (leg_pos == leg_last);
   assign dir      = dir_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q     <= DIR_DN;
         leg_pos   <= '0;
         first_leg <= 1'b1;
      end else if (!en) begin
         dir_q     <= DIR_DN;
         leg_pos   <= '0;
         first_leg <= 1'b1;
      end else if (tick) begin
         if (leg_end) begin
            dir_q     <= (dir_q == DIR_DN) ? DIR_UP : DIR_DN;
            leg_pos   <= '0;
            first_leg <= 1'b0;
         end else begin
            leg_pos   <= leg_pos + 1'b1;
         end
      end
   end

endmodule

// File: rtl/ssc_accum.sv
// Holds the signed offset (modulo word width) and registers base+offset.
module ssc_accum
   import ssc_tri_pkg::*;
#(
   parameter int W     = 26,
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick,
   input  ssc_dir_e         dir,
   input  logic [CNT_W-1:0] step_size,
   input  logic [W-1:0]     base_word,
   output logic [W-1:0]     offset,
   output logic [W-1:0]     word
);

   logic [W-1:0] step_ext;

   generate
      if (CNT_W >= W) begin : g_trunc
         assign step_ext = step_size[W-1:0];
      end else begin : g_zext
         assign step_ext = {{(W-CNT_W){1'b0}}, step_size};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         offset <= '0;
         word   <= '0;
      end else if (!en) begin
         offset <= '0;
         word   <= base_word;
      end else begin
         word <= base_word + offset;
         if (tick) begin
            offset <= (dir == DIR_DN) ? (offset - step_ext) : (offset + step_ext);
         end
      end
   end

endmodule

// File: rtl/ssc_tri_mod.sv
module ssc_tri_mod
   import ssc_tri_pkg::*;
#(
   parameter int INT_W     = 8,
   parameter int FRAC_W    = 18,
   parameter int CNT_W     = 16,
   parameter bit CENTER_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [INT_W-1:0]  base_int,
   input  logic [FRAC_W-1:0] base_frac,
   input  logic [CNT_W-1:0]  step_size,
   input  logic [CNT_W-1:0]  half_per,
   input  logic [CNT_W-1:0]  adj_per,
   input  logic [1:0]        spread_ctrl,
   output logic [INT_W-1:0]  div_int,
   output logic [FRAC_W-1:0] div_frac
);

   localparam int W = INT_W + FRAC_W;

   generate
      if (INT_W < 1 || FRAC_W < 1) begin : g_bad_word
         $error("ssc_tri_mod: word fields must be at least one bit");
      end
      if (CNT_W < 1 || CNT_W > 31) begin : g_bad_cnt
         $error("ssc_tri_mod: CNT_W must be in 1..31");
      end
   endgenerate

   logic         en_w;
   logic         ctr_w;
   logic         tick_w;
   ssc_dir_e     dir_w;
   logic [W-1:0] off_w;
   logic [W-1:0] word_w;

   assign en_w  = spread_ctrl[CTRL_EN_BIT];
   assign ctr_w = spread_ctrl[CTRL_CTR_BIT];

   ssc_tick_gen #(.CNT_W(CNT_W)) tick_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en_w),
      .adj_per (adj_per),
      .tick    (tick_w)
   );

   ssc_leg_ctrl #(.CNT_W(CNT_W), .CENTER_EN(CENTER_EN)) leg_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en_w),
      .center   (ctr_w),
      .tick     (tick_w),
      .half_per (half_per),
      .dir      (dir_w)
   );

   ssc_accum #(.W(W), .CNT_W(CNT_W)) acc_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en_w),
      .tick      (tick_w),
      .dir       (dir_w),
      .step_size (step_size),
      .base_word ({base_int, base_frac}),
      .offset    (off_w),
      .word      (word_w)
   );

   assign div_int  = word_w[W-1:FRAC_W];
   assign div_frac = word_w[FRAC_W-1:0];

endmodule

// File: rtl/ssc_tri_mod_chk.sv
module ssc_tri_mod_chk
   import ssc_tri_pkg::*;
#(
   parameter int INT_W  = 8,
   parameter int FRAC_W = 18,
   parameter int CNT_W  = 16
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    en,
   input logic                    tick,
   input ssc_dir_e                dir,
   input logic [INT_W+FRAC_W-1:0] off,
   input logic [INT_W-1:0]        base_int,
   input logic [FRAC_W-1:0]       base_frac,
   input logic [CNT_W-1:0]        step_size,
   input logic [CNT_W-1:0]        adj_per,
   input logic [INT_W-1:0]        div_int,
   input logic [FRAC_W-1:0]       div_frac
);

   localparam int W = INT_W + FRAC_W;

   logic [W-1:0] step_w;
   assign step_w = W'(step_size);

   // R2: disabled output follows the base word one cycle later
   p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> ({div_int, div_frac} == $past({base_int, base_frac})));

   // R7: disabling clears offset and direction
   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (off == '0 && dir == DIR_DN));

   // R3: offset only moves on a step strobe
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !tick) |=> (off == $past(off)));

   // R3: strobes are spaced when adj_per is non-zero
   p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && adj_per != '0) |=> !tick);

   // R4: each strobe moves the offset by exactly one step
   p_step_size_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> ((off == $past(off) + $past(step_w)) || (off == $past(off) - $past(step_w))));

   // R5: direction only changes on a step strobe
   p_dir_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !tick) |=> $stable(dir));

endmodule

bind ssc_tri_mod ssc_tri_mod_chk #(
   .INT_W  (INT_W),
   .FRAC_W (FRAC_W),
   .CNT_W  (CNT_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .en        (en_w),
   .tick      (tick_w),
   .dir       (dir_w),
   .off       (off_w),
   .base_int  (base_int),
   .base_frac (base_frac),
   .step_size (step_size),
   .adj_per   (adj_per),
   .div_int   (div_int),
   .div_frac  (div_frac)
);

// File: tb/ssc_tri_mod_tb_top.sv
module ssc_tri_mod_tb_top;

   localparam int  INT_W  = 8;
   localparam int  FRAC_W = 18;
   localparam int  CNT_W  = 16;
   localparam int  W      = INT_W + FRAC_W;
   localparam longint MASK = (64'sd1 <<< W) - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [INT_W-1:0]  base_int = '0;
   logic [FRAC_W-1:0] base_frac = '0;
   logic [CNT_W-1:0]  step_size = '0;
   logic [CNT_W-1:0]  half_per = '0;
   logic [CNT_W-1:0]  adj_per = '0;
   logic [1:0]        spread_ctrl = 2'b00;
   logic [INT_W-1:0]  div_int;
   logic [FRAC_W-1:0] div_frac;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;   // 250 MHz

   ssc_tri_mod #(.INT_W(INT_W), .FRAC_W(FRAC_W), .CNT_W(CNT_W)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .base_int    (base_int),
      .base_frac   (base_frac),
      .step_size   (step_size),
      .half_per    (half_per),
      .adj_per     (adj_per),
      .spread_ctrl (spread_ctrl),
      .div_int     (div_int),
      .div_frac    (div_frac)
   );

   task automatic chk(input string tag, input longint got, input longint exp);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   function automatic longint out_now();
      return longint'({div_int, div_frac});
   endfunction

   // Offset (in fraction LSBs) after t steps, from R5/R6
   function automatic longint tri_off(input longint t, input longint h,
                                      input longint s, input bit ctr);
      longint l, f, q, k;
      l = h + 1;
      if (!ctr) begin
         q = t % (2 * l);
         k = (q <= l) ? q : (2 * l - q);
         return -k * s;
      end
      f = (l + 1) / 2;
      if (t <= f) return -t * s;
      q = (t - f) % (2 * l);
      k = (q <= l) ? q : (2 * l - q);
      return (k - f) * s;
   endfunction

   task automatic run_case(input string tag, input int a, input int h, input bit ctr,
                           input int s, input int bi, input int bf, input int ncyc);
      longint base;
      @(negedge clk);
      base_int    = INT_W'(bi);
      base_frac   = FRAC_W'(bf);
      step_size   = CNT_W'(s);
      half_per    = CNT_W'(h);
      adj_per     = CNT_W'(a);
      spread_ctrl = {1'b1, ctr};
      base = (longint'(bi) <<< FRAC_W) + longint'(bf);
      for (int m = 1; m <= ncyc; m++) begin
         longint t;
         @(negedge clk);
         t = longint'((m - 1) / (a + 1));   // R3 step cadence
         chk(tag, out_now(), (base + tri_off(t, h, s, ctr)) & MASK);
      end
      spread_ctrl = {1'b0, ctr};
      @(negedge clk);
      chk("R7", out_now(), base & MASK);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      // R1: output zero in reset even with enable and base applied
      base_int    = 8'h33;
      base_frac   = 18'h1_2345;
      step_size   = 16'd7;
      spread_ctrl = 2'b11;
      repeat (3) @(negedge clk);
      chk("R1", out_now(), 64'd0);
      @(negedge clk);
      chk("R1", out_now(), 64'd0);
      spread_ctrl = 2'b01;
      rst_n = 1'b1;

      // R2: disabled, center bit set, output follows base
      @(negedge clk);
      chk("R2", out_now(), (longint'(8'h33) <<< FRAC_W) + 64'h1_2345);
      base_int  = 8'h12;
      base_frac = 18'h2_3456;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk("R2", out_now(), (longint'(8'h12) <<< FRAC_W) + 64'h2_3456);
      end
      spread_ctrl = 2'b00;
      @(negedge clk);
      chk("R2", out_now(), (longint'(8'h12) <<< FRAC_W) + 64'h2_3456);

      // Sweep: R3 spacing, R5 down legs, R6 center legs, R4 carry near frac top
      for (int a = 0; a <= 2; a++) begin
         for (int hi = 0; hi < 5; hi++) begin
            for (int md = 0; md < 2; md++) begin
               for (int si = 0; si < 2; si++) begin
                  int h;
                  int s;
                  h = (hi == 4) ? 5 : hi;
                  s = (si == 0) ? 3 : 16'hFFFF;
                  run_case(md != 0 ? "R6" : "R5", a, h, md[0], s,
                           8'h40, 18'h3_FFF0, (a + 1) * (3 * (h + 1) + 2) + 1);
               end
            end
         end
      end

      // R4: borrow through zero wraps the whole word
      run_case("R4", 0, 2, 1'b0, 5, 0, 0, 12);
      // R4: carry across integer part in center mode
      run_case("R4", 1, 3, 1'b1, 16'hFFFF, 8'hFF, 18'h3_0000, 30);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule